// File: doc/BRIEF.md
# MSI capture and interrupt aggregator

This block collects message-signalled interrupts and presents them to the host as a single level interrupt. Software programs a 64-bit target address, a 32-bit per-vector enable, a 32-bit mask and a 32-bit pending-status word through a simple register write/read port. A separate inbound write port carries posted writes from the link side. When such a write lands inside the 4-byte window at the programmed address, its data value names a vector, and the matching status bit is set if that vector is enabled.

The interrupt output is a registered level. A capture raises it when any pending bit is unmasked. A software write to the status word toggles bits (XOR), and the output drops only once the status word becomes all zero. Changing the mask by itself never moves the output. The capture window is open only while the enable word is nonzero, so with all vectors disabled the inbound port is ignored entirely.

Top module: `msi_irq_collector`

## Requirements
- R1: After reset the address, enable, mask and status registers read as zero and `irq` is low.
- R2: A write to offset 0x820 replaces only address bits 31:0 and a write to offset 0x824 replaces only bits 63:32; both halves read back at those offsets.
- R3: Enable, mask and status read back at offsets 0x828, 0x82C and 0x830; any other read offset returns zero.
- R4: An inbound write hitting the window with data value v (0 to 31) sets status bit v only if enable bit v is 1; a disabled vector leaves status unchanged.
- R5: An inbound write with a data value of 32 or more sets no status bit.
- R6: The window covers the four byte addresses base to base+3; inbound writes below or above it have no effect.
- R7: While the enable register is zero no inbound write is captured; the window opens again on the cycle after enable becomes nonzero.
- R8: On the cycle after a window hit, `irq` is 1 if any status bit is set whose mask bit is clear; a capture into masked bits only does not raise `irq`.
- R9: A status write XORs the written value into status; `irq` goes low on the next cycle when the result is zero and is otherwise left as it was.
- R10: A write to the mask register does not change `irq`.
- R11: When a status write and a window hit occur in the same cycle, the new status is (old XOR written value) OR the captured bit, and the raise rule of R8 is applied after the clear rule of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 12 | Register write offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 12 | Register read offset |
| cfg_rdata | output | 32 | Register read data (combinational) |
| msi_valid | input | 1 | Inbound posted write strobe |
| msi_addr | input | 64 | Inbound write address |
| msi_data | input | 32 | Inbound write data (vector number) |
| irq | output | 1 | Aggregated level interrupt |

## Verification
The hardest state to reach is an output that stays low while unmasked status bits are pending: it arises only when bits are captured under a mask and the mask is later cleared, or when a status write sets bits by XOR. The stimulus builds both on purpose, then checks that a mask write leaves the output alone. It also lines up a status write and a window hit in the same cycle, and probes the window edges at base-1, base+3 and base+4 with a base whose upper half is nonzero.

// File: rtl/msi_collect_pkg.sv
package msi_collect_pkg;
    localparam int MSI_AW   = 64;
    localparam int MSI_VN   = 32;
    localparam int CFG_AW   = 12;
    localparam int CFG_DW   = 32;
    localparam int WIN_SZ   = 4;

    localparam logic [CFG_AW-1:0] OFS_BASE_LO = 12'h820;
    localparam logic [CFG_AW-1:0] OFS_BASE_HI = 12'h824;
    localparam logic [CFG_AW-1:0] OFS_ENABLE  = 12'h828;
    localparam logic [CFG_AW-1:0] OFS_MASK    = 12'h82C;
    localparam logic [CFG_AW-1:0] OFS_STATUS  = 12'h830;

    typedef struct packed {
        logic [MSI_AW-1:0] base;
        logic [MSI_VN-1:0] enable;
        logic [MSI_VN-1:0] mask;
        logic [MSI_VN-1:0] status;
        logic              irq;
    } collect_state_t;
endpackage

// File: rtl/msi_window_match.sv
module msi_window_match #(
    parameter int AW      = 64,
    parameter int WIN_LEN = 4
) (
    input  logic          open,
    input  logic          valid,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    logic [AW-1:0] offset;
    always_comb begin
        offset = addr - base;
        hit    = open && valid && (offset < AW'(WIN_LEN));
    end
endmodule

// File: rtl/msi_vector_decode.sv
module msi_vector_decode #(
    parameter int DW = 32,
    parameter int VN = 32
) (
    input  logic [DW-1:0] value,
    output logic [VN-1:0] onehot
);
    for (genvar i = 0; i < VN; i++) begin : g_bit
        assign onehot[i] = (value == DW'(i));
    end
endmodule

// File: rtl/msi_irq_collector.sv
module msi_irq_collector
    import msi_collect_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_waddr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic [CFG_AW-1:0] cfg_raddr,
    output logic [CFG_DW-1:0] cfg_rdata,
    input  logic              msi_valid,
    input  logic [MSI_AW-1:0] msi_addr,
    input  logic [CFG_DW-1:0] msi_data,
    output logic              irq
);
    localparam int HALF = MSI_AW / 2;

    collect_state_t    st_d, st_q;
    logic              win_hit;
    logic [MSI_VN-1:0] vec_onehot;
    logic [MSI_VN-1:0] vec_cap;
    logic              status_wr;

    msi_window_match #(.AW(MSI_AW), .WIN_LEN(WIN_SZ)) u_window (
        .open  (|st_q.enable),
        .valid (msi_valid),
        .base  (st_q.base),
        .addr  (msi_addr),
        .hit   (win_hit)
    );

    msi_vector_decode #(.DW(CFG_DW), .VN(MSI_VN)) u_decode (
        .value  (msi_data),
        .onehot (vec_onehot)
    );

    always_comb begin
        st_d      = st_q;
        vec_cap   = vec_onehot & st_q.enable & {MSI_VN{win_hit}};
        status_wr = cfg_we && (cfg_waddr == OFS_STATUS);
        if (cfg_we) begin
            case (cfg_waddr)
                OFS_BASE_LO: st_d.base[HALF-1:0]      = cfg_wdata;
                OFS_BASE_HI: st_d.base[MSI_AW-1:HALF] = cfg_wdata;
                OFS_ENABLE:  st_d.enable              = cfg_wdata;
                OFS_MASK:    st_d.mask                = cfg_wdata;
                OFS_STATUS:  st_d.status              = st_q.status ^ cfg_wdata;
                default: ;
            endcase
        end
        st_d.status = st_d.status | vec_cap;
        // clear rule first, then raise rule on a window hit
        if (status_wr && (st_d.status == '0)) st_d.irq = 1'b0;
        if (win_hit && (|(st_d.status & ~st_q.mask))) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (cfg_raddr)
            OFS_BASE_LO: cfg_rdata = st_q.base[HALF-1:0];
            OFS_BASE_HI: cfg_rdata = st_q.base[MSI_AW-1:HALF];
            OFS_ENABLE:  cfg_rdata = st_q.enable;
            OFS_MASK:    cfg_rdata = st_q.mask;
            OFS_STATUS:  cfg_rdata = st_q.status;
            default:     cfg_rdata = '0;
        endcase
    end

    assign irq = st_q.irq;

    logic [MSI_AW-1:0] base_q;
    logic [MSI_VN-1:0] enable_q, mask_q, status_q;
    assign base_q   = st_q.base;
    assign enable_q = st_q.enable;
    assign mask_q   = st_q.mask;
    assign status_q = st_q.status;
endmodule

// File: rtl/msi_irq_collector_chk.sv
module msi_irq_collector_chk
    import msi_collect_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_waddr,
    input logic              msi_valid,
    input logic [CFG_DW-1:0] msi_data,
    input logic              win_hit,
    input logic [MSI_AW-1:0] base_q,
    input logic [MSI_VN-1:0] enable_q,
    input logic [MSI_VN-1:0] mask_q,
    input logic [MSI_VN-1:0] status_q,
    input logic              irq
);
    logic st_wr;
    assign st_wr = cfg_we && (cfg_waddr == OFS_STATUS);

    // R2
    base_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && (cfg_waddr == OFS_BASE_LO) |=> base_q[MSI_AW-1:MSI_AW/2] == $past(base_q[MSI_AW-1:MSI_AW/2]));

    // R5
    big_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid && (msi_data >= CFG_DW'(MSI_VN)) && !st_wr |=> $stable(status_q));

    // R7
    closed_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) && !st_wr |=> $stable(status_q));

    // R8
    raise_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit && (|(status_q & ~mask_q)) |=> irq);

    // R8
    rise_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(win_hit));

    // R9
    zero_status_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |-> !irq);

    // R10
    mask_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && (cfg_waddr == OFS_MASK) && !msi_valid |=> $stable(irq));
endmodule

bind msi_irq_collector msi_irq_collector_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_waddr (cfg_waddr),
    .msi_valid (msi_valid),
    .msi_data  (msi_data),
    .win_hit   (win_hit),
    .base_q    (base_q),
    .enable_q  (enable_q),
    .mask_q    (mask_q),
    .status_q  (status_q),
    .irq       (irq)
);

// File: tb/tb_msi_irq_collector.sv
`timescale 1ns/1ps
module tb_msi_irq_collector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_waddr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [11:0] cfg_raddr = '0;
    logic [31:0] cfg_rdata;
    logic        msi_valid = 1'b0;
    logic [63:0] msi_addr = '0;
    logic [31:0] msi_data = '0;
    logic        irq;

    always #2 clk = ~clk;

    msi_irq_collector dut (.*);

    localparam logic [11:0] A_LO = 12'h820, A_HI = 12'h824, A_EN = 12'h828,
                            A_MK = 12'h82C, A_ST = 12'h830;

    typedef struct {
        bit          is_irq;
        logic [11:0] addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference state
    logic [63:0] m_base = '0;
    logic [31:0] m_en = '0, m_mask = '0, m_st = '0;
    logic        m_irq = 1'b0;

    // monitor: pops expectations after the edge that produced them
    initial forever begin
        @(negedge clk);
        #0.2;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            cfg_raddr = it.addr;
            #0.1;
            act = it.is_irq ? {31'b0, irq} : cfg_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: %s addr %h actual %h expected %h", it.tag,
                         it.is_irq ? "irq" : "reg", it.addr, act, it.exp);
            end
        end
    end

    task automatic push_reg(input logic [11:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.is_irq = 0; it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic push_irq(input string tag);
        item_t it;
        it.is_irq = 1; it.addr = 12'h0; it.exp = {31'b0, m_irq}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        wait (sb_q.size() == 0);
    endtask

    task automatic expect_state(input string tag);
        push_reg(A_ST, m_st, tag);
        push_irq(tag);
        drain();
    endtask

    function automatic void model_cfg(input logic [11:0] a, input logic [31:0] d);
        case (a)
            A_LO: m_base[31:0]  = d;
            A_HI: m_base[63:32] = d;
            A_EN: m_en   = d;
            A_MK: m_mask = d;
            A_ST: begin m_st = m_st ^ d; end
            default: ;
        endcase
    endfunction

    // one cycle with optional register write and optional inbound write
    task automatic cycle(input bit we, input logic [11:0] a, input logic [31:0] d,
                         input bit mv, input logic [63:0] ma, input logic [31:0] md);
        logic [63:0] off;
        bit hit;
        logic [31:0] old_mask;
        old_mask = m_mask;
        off = ma - m_base;
        hit = mv && (m_en != 0) && (off < 64'd4);
        @(negedge clk);
        cfg_we = we; cfg_waddr = a; cfg_wdata = d;
        msi_valid = mv; msi_addr = ma; msi_data = md;
        if (we) model_cfg(a, d);
        if (hit && md < 32) m_st = m_st | ((32'h1 << md[4:0]) & m_en);
        if (we && a == A_ST && m_st == 0) m_irq = 1'b0;
        if (hit && ((m_st & ~old_mask) != 0)) m_irq = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; msi_valid = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cycle(1'b1, a, d, 1'b0, '0, '0);
    endtask

    task automatic msi(input logic [63:0] ma, input logic [31:0] md);
        cycle(1'b0, 12'h0, '0, 1'b1, ma, md);
    endtask

    localparam logic [63:0] BASE = 64'h0000_0001_FEE0_1000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        push_reg(A_LO, 0, "R1"); push_reg(A_HI, 0, "R1"); push_reg(A_EN, 0, "R1");
        push_reg(A_MK, 0, "R1"); push_reg(A_ST, 0, "R1"); push_irq("R1");
        drain();

        // R2 address halves
        wr(A_LO, 32'hFEE0_0000); wr(A_HI, 32'h0000_0002);
        push_reg(A_LO, 32'hFEE0_0000, "R2"); push_reg(A_HI, 32'h2, "R2"); drain();
        wr(A_LO, 32'hFEE0_1000);
        push_reg(A_HI, 32'h2, "R2"); push_reg(A_LO, 32'hFEE0_1000, "R2"); drain();
        wr(A_HI, 32'h0000_0001);
        push_reg(A_LO, 32'hFEE0_1000, "R2"); push_reg(A_HI, 32'h1, "R2"); drain();
        // R3 unmapped offset
        push_reg(12'h834, 0, "R3"); push_reg(12'h000, 0, "R3"); drain();

        // R7 closed window
        msi(BASE, 3); expect_state("R7");

        // R3 / R4 / R8 basic capture
        wr(A_EN, 32'h0000_00FF); push_reg(A_EN, 32'hFF, "R3"); drain();
        msi(BASE, 3); expect_state("R4");
        push_reg(A_ST, 32'h8, "R8"); drain();
        // R5 out-of-range vector
        msi(BASE, 40); expect_state("R5");
        // R4 disabled vector
        msi(BASE, 9); expect_state("R4");
        // R6 window edges
        msi(BASE + 4, 2); expect_state("R6");
        msi(BASE - 1, 1); expect_state("R6");
        msi(BASE + 3, 2); expect_state("R6");
        push_reg(A_ST, 32'hC, "R6"); drain();

        // R9 XOR clear
        wr(A_ST, 32'h8); expect_state("R9");
        wr(A_ST, 32'h4); expect_state("R9");
        wr(A_ST, 32'h1); expect_state("R9");
        wr(A_ST, 32'h1); expect_state("R9");

        // R8 masked capture, R10 mask write
        wr(A_MK, 32'hF0); push_reg(A_MK, 32'hF0, "R3"); drain();
        msi(BASE, 5); expect_state("R8");
        wr(A_MK, 32'h0); expect_state("R10");
        msi(BASE, 40); expect_state("R8");
        wr(A_ST, 32'h20); expect_state("R9");
        msi(BASE + 1, 1); expect_state("R8");
        wr(A_MK, 32'hFF); expect_state("R10");
        wr(A_ST, 32'h2); expect_state("R9");
        wr(A_MK, 32'h0);

        // R11 simultaneous status write and capture
        cycle(1'b1, A_ST, 32'h1, 1'b1, BASE + 2, 4); expect_state("R11");
        push_reg(A_ST, 32'h11, "R11"); drain();
        cycle(1'b1, A_ST, 32'h11, 1'b1, BASE, 6); expect_state("R11");
        wr(A_ST, 32'h40); expect_state("R11");

        // R7 enable to zero and back
        wr(A_EN, 32'h0); msi(BASE, 2); expect_state("R7");
        wr(A_EN, 32'h4); msi(BASE, 2); expect_state("R7");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule